// File: doc/BRIEF.md
# Signed Audio Crossfade Mixer

This block mixes two signed audio samples into one. The first sample is scaled by an unsigned fade coefficient and the second by the bit-inverted coefficient. The two products are added, and the upper half of the sum becomes the output sample. A caller lowers the coefficient step by step across a loop boundary, so the output slides from the first sample to the second without a click. When no fade is in progress, the first sample passes through untouched.

Each start strobe loads one set of operands. After a fixed latency a one-cycle valid pulse presents the matching result. A start may be issued on every clock. The coefficient generator and the sample storage sit outside this block.

Top module: `xfade_mix`

## Requirements
- R1: Both samples are two's-complement signed values of SMP_W bits. The coefficient is an unsigned COEF_W-bit value, so a coefficient with its top bit set (for example 0x8000) gives a positive weight of about one half.
- R2: The second sample's weight is the bitwise inverse of the coefficient. With a coefficient of 0 and the fade active, the output is floor(s2*0xFFFF/0x10000): s2-1 for a positive s2 and exactly s2 for a negative s2.
- R3: While the fade is active, the output is bits [SMP_W+COEF_W-1:COEF_W] of s1*c + s2*~c. This equals floor(sum / 2^COEF_W).
- R4: While the active flag is low, the output equals the first sample exactly, whatever the coefficient and second sample are.
- R5: A start strobe sampled on a rising clock edge produces valid_o high for exactly one cycle, 1+REG_PRODUCTS edges later (2 with the defaults), with the matching result on result_o.
- R6: Without a start strobe, valid_o stays low, no matter how the data inputs change.
- R7: No input combination overflows the output. Full-scale positive samples on both inputs give +32766 or +32767, and full-scale negative samples on both inputs give exactly -32768.
- R8: During and right after reset, valid_o is low and result_o is zero.
- R9: Start strobes on consecutive cycles produce results on consecutive cycles, in issue order, each one matching its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load the operands on this edge |
| active_i | input | 1 | 1: blend the two samples, 0: pass the first sample through |
| smp_a_i | input | SMP_W | Signed sample at the current read position |
| smp_b_i | input | SMP_W | Signed sample from across the loop boundary |
| coef_i | input | COEF_W | Unsigned fade coefficient (weight of smp_a_i) |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | SMP_W | Signed mixed sample |

## Verification
The bench builds the block with its default parameters: 16-bit samples, a 16-bit coefficient and the registered-product variant. This gives a two-cycle latency, so the bench checks the pipeline's ordering under back-to-back strobes as well as the single-strobe timing. With 16-bit operands it can reach the full-scale extremes, the 0x8000 signedness trap and the zero-coefficient floor rounding. It also runs a complete 0xFF80-down-by-128 fade sweep, comparing every step against an arithmetic model.

// File: rtl/xfade_pkg.sv
package xfade_pkg;
   localparam int XF_DEF_SMP_W  = 16;
   localparam int XF_DEF_COEF_W = 16;

   // Output-stage variant selection
   typedef enum logic {
      XF_COMB_PRODUCTS = 1'b0,
      XF_REG_PRODUCTS  = 1'b1
   } xf_variant_e;
endpackage

// File: rtl/xf_wmul.sv
module xf_wmul #(
   parameter int SMP_W  = 16,
   parameter int COEF_W = 16,
   localparam int PW    = SMP_W + COEF_W + 1
) (
   input  logic signed [SMP_W-1:0]  smp,
   input  logic        [COEF_W-1:0] wgt,
   output logic signed [PW-1:0]     prod
);
   logic signed [PW-1:0] smp_x;
   logic signed [PW-1:0] wgt_x;

   always_comb begin
      smp_x = {{(COEF_W+1){smp[SMP_W-1]}}, smp};
      wgt_x = {{(SMP_W+1){1'b0}}, wgt};
      prod  = smp_x * wgt_x;
   end
endmodule

// File: rtl/xf_sum.sv
module xf_sum #(
   parameter int SMP_W  = 16,
   parameter int COEF_W = 16,
   localparam int PW    = SMP_W + COEF_W + 1,
   localparam int SW    = PW + 1,
   localparam int HW    = SW - COEF_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chk_en,
   input  logic signed [PW-1:0]    prod_a,
   input  logic signed [PW-1:0]    prod_b,
   output logic signed [SMP_W-1:0] mix
);
   logic signed [SW-1:0] total;
   logic signed [SW-1:0] shifted;
   logic        [HW-SMP_W:0] upper;

   always_comb begin
      total   = {prod_a[PW-1], prod_a} + {prod_b[PW-1], prod_b};
      shifted = total >>> COEF_W;
      mix     = shifted[SMP_W-1:0];
      upper   = shifted[HW-1:SMP_W-1];
   end

   // Everything above the kept slice must be sign copies
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> ($countones(upper) == 0 || $countones(upper) == HW - SMP_W + 1));
endmodule

// File: rtl/xfade_mix.sv
module xfade_mix
   import xfade_pkg::*;
#(
   parameter int SMP_W        = XF_DEF_SMP_W,
   parameter int COEF_W       = XF_DEF_COEF_W,
   parameter bit REG_PRODUCTS = 1'b1,
   localparam int PW          = SMP_W + COEF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              active_i,
   input  logic [SMP_W-1:0]  smp_a_i,
   input  logic [SMP_W-1:0]  smp_b_i,
   input  logic [COEF_W-1:0] coef_i,
   output logic              valid_o,
   output logic [SMP_W-1:0]  result_o
);
   if (SMP_W < 2 || SMP_W > 32) begin : g_bad_smp_w
      $error("xfade_mix: SMP_W must lie in 2..32");
   end
   if (COEF_W < 2 || COEF_W > 32) begin : g_bad_coef_w
      $error("xfade_mix: COEF_W must lie in 2..32");
   end

   localparam xf_variant_e VARIANT = REG_PRODUCTS ? XF_REG_PRODUCTS : XF_COMB_PRODUCTS;

   logic signed [PW-1:0]    prod_a, prod_b;
   logic signed [PW-1:0]    sum_in_a, sum_in_b;
   logic                    sel_v, sel_act;
   logic [SMP_W-1:0]        sel_smp;
   logic signed [SMP_W-1:0] mix;
   logic [COEF_W-1:0]       coef_inv;
   logic                    valid_q;
   logic [SMP_W-1:0]        result_q;

   assign coef_inv = ~coef_i;

   xf_wmul #(.SMP_W(SMP_W), .COEF_W(COEF_W)) u_mul_a (
      .smp(smp_a_i), .wgt(coef_i), .prod(prod_a));
   xf_wmul #(.SMP_W(SMP_W), .COEF_W(COEF_W)) u_mul_b (
      .smp(smp_b_i), .wgt(coef_inv), .prod(prod_b));

   if (VARIANT == XF_REG_PRODUCTS) begin : g_reg
      logic signed [PW-1:0] pa_q, pb_q;
      logic                 v1_q, act1_q;
      logic [SMP_W-1:0]     smp1_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v1_q   <= 1'b0;
            act1_q <= 1'b0;
            smp1_q <= '0;
            pa_q   <= '0;
            pb_q   <= '0;
         end else begin
            v1_q <= start_i;
            if (start_i) begin
               act1_q <= active_i;
               smp1_q <= smp_a_i;
               pa_q   <= prod_a;
               pb_q   <= prod_b;
            end
         end
      end

      assign sum_in_a = pa_q;
      assign sum_in_b = pb_q;
      assign sel_v    = v1_q;
      assign sel_act  = act1_q;
      assign sel_smp  = smp1_q;

      p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(start_i, 2) |-> valid_o);
      p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(start_i, 2) |-> !valid_o);
      p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_o && !$past(active_i, 2)) |-> result_o == $past(smp_a_i, 2));
   end else begin : g_comb
      assign sum_in_a = prod_a;
      assign sum_in_b = prod_b;
      assign sel_v    = start_i;
      assign sel_act  = active_i;
      assign sel_smp  = smp_a_i;

      p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(start_i) |-> valid_o);
      p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(start_i) |-> !valid_o);
      p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_o && !$past(active_i)) |-> result_o == $past(smp_a_i));
   end

   xf_sum #(.SMP_W(SMP_W), .COEF_W(COEF_W)) u_sum (
      .clk(clk), .rst_n(rst_n), .chk_en(sel_v),
      .prod_a(sum_in_a), .prod_b(sum_in_b), .mix(mix));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         result_q <= '0;
      end else begin
         valid_q <= sel_v;
         if (sel_v) result_q <= sel_act ? mix : sel_smp;
      end
   end

   assign valid_o  = valid_q;
   assign result_o = result_q;

   p_reset_r8: assert property (@(posedge clk)
      $past(!rst_n) |-> (!valid_o && result_o == '0));
endmodule

// File: tb/test_xfade_mix.sv
module test_xfade_mix;
   localparam int LAT = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, active_i = 1'b0;
   logic [15:0] smp_a_i = '0, smp_b_i = '0, coef_i = '0;
   logic valid_o;
   logic [15:0] result_o;

   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;

   xfade_mix i_xfade_mix (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .active_i(active_i),
      .smp_a_i(smp_a_i), .smp_b_i(smp_b_i), .coef_i(coef_i),
      .valid_o(valid_o), .result_o(result_o));

   function automatic int model(input int s1, input int s2, input int c, input bit act);
      longint p;
      if (!act) return s1;
      p = longint'(s1) * longint'(c) + longint'(s2) * longint'(65535 - c);
      return int'(p >>> 16);
   endfunction

   task automatic check(input string req, input int act_v, input int exp_v);
      checks++;
      if (act_v != exp_v) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
      end
   endtask

   task automatic run_one(input string req, input int s1, input int s2, input int c, input bit act);
      @(negedge clk);
      smp_a_i = s1[15:0]; smp_b_i = s2[15:0]; coef_i = c[15:0];
      active_i = act; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      smp_a_i = 16'h1234; smp_b_i = 16'h4321; coef_i = 16'h5555; active_i = ~act;
      repeat (LAT - 1) begin
         check({req, " early valid"}, int'(valid_o), 0);
         @(negedge clk);
      end
      check({req, " valid"}, int'(valid_o), 1);
      check({req, " data"}, int'($signed(result_o)), model(s1, s2, c, act));
      @(negedge clk);
      check({req, " pulse width"}, int'(valid_o), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 valid in reset", int'(valid_o), 0);
      check("R8 result in reset", int'(result_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 valid after reset", int'(valid_o), 0);
      check("R8 result after reset", int'(result_o), 0);
   endtask

   task automatic t_bypass();
      run_one("R4", 12345, -30000, 0, 1'b0);
      run_one("R4", -32768, 32767, 16'hFFFF, 1'b0);
      run_one("R4", -1, 5, 16'h8000, 1'b0);
   endtask

   task automatic t_signedness();
      run_one("R1", -20000, 20000, 16'h8000, 1'b1);
      run_one("R1", 7000, -7000, 16'hC000, 1'b1);
   endtask

   task automatic t_complement();
      run_one("R2", 500, 1000, 0, 1'b1);
      run_one("R2", 500, -1000, 0, 1'b1);
      run_one("R3", 1000, -3, 16'hFFFF, 1'b1);
      run_one("R3", -1000, 3, 16'hFFFF, 1'b1);
   endtask

   task automatic t_sweep();
      for (int k = 0; k * 128 <= 16'hFF80; k++)
         run_one("R3 sweep", 12000, -9000, 16'hFF80 - k * 128, 1'b1);
   endtask

   task automatic t_extremes();
      int cs[4] = '{0, 16'h8000, 16'hFF80, 16'hFFFF};
      foreach (cs[i]) begin
         run_one("R7 max", 32767, 32767, cs[i], 1'b1);
         run_one("R7 min", -32768, -32768, cs[i], 1'b1);
         run_one("R7 mixed", 32767, -32768, cs[i], 1'b1);
      end
   endtask

   task automatic t_idle();
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         smp_a_i = 16'(k * 911); smp_b_i = 16'(k * 377); coef_i = 16'(k * 4099);
         active_i = k[0];
         check("R6 no start", int'(valid_o), 0);
      end
   endtask

   task automatic t_burst();
      int s1[4] = '{100, -2000, 32767, -5};
      int s2[4] = '{-100, 3000, -32768, 9};
      int cc[4] = '{16'hFF80, 16'h0080, 16'h4000, 0};
      bit aa[4] = '{1'b1, 1'b1, 1'b0, 1'b1};
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            check("R9 burst valid", int'(valid_o), 1);
            check("R9 burst data", int'($signed(result_o)),
                  model(s1[k-2], s2[k-2], cc[k-2], aa[k-2]));
         end
         if (k < 4) begin
            smp_a_i = s1[k][15:0]; smp_b_i = s2[k][15:0]; coef_i = cc[k][15:0];
            active_i = aa[k]; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
      end
      @(negedge clk);
      check("R9 burst end", int'(valid_o), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_bypass();
      t_signedness();
      t_complement();
      t_extremes();
      t_idle();
      t_burst();
      t_sweep();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule